// File: doc/BRIEF.md
# Hardware Array-Based Queue Lock

This block arbitrates one shared lock among a fixed set of requesters and hands it out strictly in arrival order. Each requester raises a one-cycle acquire pulse; the block atomically hands it the current value of a next-ticket counter, then advances that counter. The issued ticket also names a slot in a serve-flag array. The requester holds the lock while the flag of its own slot is set, and it sees this as a level on its grant line.

The holder ends its tenure with a one-cycle release pulse. This clears the flag of its own slot and sets the flag of the slot one past it, so each release wakes exactly one successor. If nobody holds that successor ticket yet, the flag stays set and waits. The next requester to arrive draws that ticket and is granted at once. Tickets and slots wrap modulo the number of slots. The slot count must be at least the number of requesters.

When several acquires arrive in one cycle, lower requester indices get lower tickets. A release from a requester that does not hold the lock changes nothing. Instead it raises an error pulse for one cycle.

Top module: `abql_queue_lock`

## Requirements
- R1: One cycle after reset is released, every grant is 0 and the error output is 0. The first accepted acquire draws ticket 0 and is granted in the cycle after its pulse.
- R2: An acquire pulse from an idle requester makes its ticket field, bits [i*TW +: TW] of `ticket`, show the pre-pulse next-ticket value one cycle later. The next-ticket value then advances by one.
- R3: At no time is more than one grant bit set.
- R4: When several idle requesters pulse acquire in the same cycle, they receive consecutive tickets in ascending requester index order.
- R5: A holder keeps its grant until it pulses release. One cycle after its release its grant is 0, and the requester holding the next ticket (modulo the slot count) is granted.
- R6: Grants are issued in the order in which acquires were accepted (FIFO).
- R7: Ticket values wrap from NUM_SLOTS-1 to 0.
- R8: A release pulse from a requester whose grant bit is 0 leaves every grant and ticket unchanged. It sets `rel_err` to 1 for exactly the following cycle.
- R9: An acquire pulse from a requester that is already waiting or holding is ignored: its ticket is unchanged and the counter does not advance.
- R10: After a release that leaves no waiter, all grants are 0. The next requester to acquire is granted in the cycle after its pulse.
- R11: A valid release and acquires from other requesters in the same cycle both take effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acq_req | input | NUM_REQ | One-cycle acquire pulse per requester |
| rel_req | input | NUM_REQ | One-cycle release pulse per requester |
| grant | output | NUM_REQ | Level: bit i set while requester i holds the lock |
| ticket | output | NUM_REQ*TW | Ticket held by each requester, field i at [i*TW +: TW] |
| rel_err | output | 1 | Pulse one cycle after a release from a non-holder |

## Verification
A holder's release and new acquires from other requesters can land in the same cycle. The counter then advances while the serve flag moves, and the newcomer may draw the very ticket whose flag is being set. The bench provokes this by driving one holder's release and one or more idle requesters' acquires on the same edge, including the case where the ticket counter wraps. A behavioural model of next ticket and now-serving index predicts the grant vector, each issued ticket and the error pulse, and a scoreboard checks that the order of grants matches the order of accepted acquires.

// File: rtl/abql_pkg.sv
// Package: shared helpers for the queue lock.
// Assumes every index passed in is below twice the slot count.
package abql_pkg;

    // Modular reduction of a sum that is known to be below 2*slots.
    function automatic int unsigned slot_wrap(input int unsigned v, input int unsigned slots);
        return (v >= slots) ? (v - slots) : v;
    endfunction

endpackage

// File: rtl/abql_ticket_alloc.sv
// Ticket allocator: holds the next-ticket counter and issues consecutive
// tickets to the requesters whose take bit is set, lowest index first.
// Assumes NUM_REQ <= NUM_SLOTS, so one subtraction completes any wrap.
module abql_ticket_alloc #(
    parameter int NUM_REQ   = 4,
    parameter int NUM_SLOTS = 4,
    localparam int TW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_REQ-1:0]    take_i,
    output logic [NUM_REQ*TW-1:0] tkt_new_o
);

    logic [TW-1:0] next_q;
    logic [TW-1:0] next_d;

    // Rank the takers in index order and derive each one's ticket.
    always_comb begin
        int unsigned run;
        run = 0;
        for (int i = 0; i < NUM_REQ; i++) begin
            tkt_new_o[i*TW +: TW] =
                TW'(abql_pkg::slot_wrap(32'(next_q) + run, NUM_SLOTS));
            run = run + 32'(take_i[i]);
        end
        next_d = TW'(abql_pkg::slot_wrap(32'(next_q) + run, NUM_SLOTS));
    end

    // Advance the counter by the number of tickets issued this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
        end else begin
            next_q <= next_d;
        end
    end

endmodule

// File: rtl/abql_serve_flags.sv
// Serve-flag array: one flag per slot, slot 0 set after reset. An advance
// clears the given slot and sets the following one (modulo NUM_SLOTS).
// Assumes at most one advance per cycle and that the caller passes the
// slot of the current holder.
module abql_serve_flags #(
    parameter int NUM_SLOTS = 4,
    localparam int TW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv_i,
    input  logic [TW-1:0]        adv_slot_i,
    output logic [NUM_SLOTS-1:0] flags_o
);

    logic [TW-1:0] succ_slot;

    // Successor slot of the releasing holder.
    always_comb begin
        succ_slot = TW'(abql_pkg::slot_wrap(32'(adv_slot_i) + 32'd1, NUM_SLOTS));
    end

    // Move the single set flag from the holder's slot to its successor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= NUM_SLOTS'(1);
        end else if (adv_i) begin
            flags_o[adv_slot_i] <= 1'b0;
            flags_o[succ_slot]  <= 1'b1;
        end
    end

endmodule

// File: rtl/abql_req_slot.sv
// Per-requester record: whether the requester is queued (waiting or
// holding) and which ticket it drew. Assumes take is only raised while
// idle and drop only while queued.
module abql_req_slot #(
    parameter int NUM_SLOTS = 4,
    localparam int TW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [TW-1:0] tkt_i,
    input  logic          drop_i,
    output logic          queued_o,
    output logic [TW-1:0] tkt_o
);

    // Record a newly drawn ticket, or leave the queue on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            queued_o <= 1'b0;
            tkt_o    <= '0;
        end else if (take_i) begin
            queued_o <= 1'b1;
            tkt_o    <= tkt_i;
        end else if (drop_i) begin
            queued_o <= 1'b0;
        end
    end

endmodule

// File: rtl/abql_queue_lock.sv
// Top: FIFO lock built from a ticket counter and a one-hot serve array.
// A requester is granted while it is queued and the flag of its slot is
// set. Assumes NUM_SLOTS >= NUM_REQ and one-cycle request pulses.
module abql_queue_lock #(
    parameter int NUM_REQ   = 4,
    parameter int NUM_SLOTS = 4,
    localparam int TW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_REQ-1:0]    acq_req,
    input  logic [NUM_REQ-1:0]    rel_req,
    output logic [NUM_REQ-1:0]    grant,
    output logic [NUM_REQ*TW-1:0] ticket,
    output logic                  rel_err
);

    logic [NUM_REQ-1:0]    queued;
    logic [NUM_REQ-1:0]    take;
    logic [NUM_REQ-1:0]    rel_ok;
    logic [NUM_REQ-1:0]    rel_bad;
    logic [NUM_REQ*TW-1:0] tkt_new;
    logic [TW-1:0]         tkt_q [NUM_REQ];
    logic [NUM_SLOTS-1:0]  flags;
    logic                  adv;
    logic [TW-1:0]         adv_slot;

    // Only idle requesters may draw a ticket.
    always_comb begin
        take = acq_req & ~queued;
    end

    // Split release pulses into valid (from the holder) and invalid ones.
    always_comb begin
        rel_ok  = rel_req & grant;
        rel_bad = rel_req & ~grant;
        adv     = |rel_ok;
    end

    // Select the slot of the releasing holder.
    always_comb begin
        adv_slot = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (rel_ok[i]) begin
                adv_slot = adv_slot | tkt_q[i];
            end
        end
    end

    abql_ticket_alloc #(
        .NUM_REQ   (NUM_REQ),
        .NUM_SLOTS (NUM_SLOTS)
    ) alloc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .tkt_new_o (tkt_new)
    );

    abql_serve_flags #(
        .NUM_SLOTS (NUM_SLOTS)
    ) flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .adv_slot_i (adv_slot),
        .flags_o    (flags)
    );

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        abql_req_slot #(
            .NUM_SLOTS (NUM_SLOTS)
        ) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .take_i   (take[g]),
            .tkt_i    (tkt_new[g*TW +: TW]),
            .drop_i   (rel_ok[g]),
            .queued_o (queued[g]),
            .tkt_o    (tkt_q[g])
        );

        // A queued requester holds the lock while its slot flag is set.
        assign grant[g] = queued[g] & flags[tkt_q[g]];
        assign ticket[g*TW +: TW] = tkt_q[g];
    end

    // Flag a release from a non-holder for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_err <= 1'b0;
        end else begin
            rel_err <= |rel_bad;
        end
    end

endmodule

// File: rtl/abql_queue_lock_chk.sv
// Checker: port-level properties of the queue lock, bound to the top.
module abql_queue_lock_chk #(
    parameter int NUM_REQ   = 4,
    parameter int NUM_SLOTS = 4,
    localparam int TW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_REQ-1:0]    acq_req,
    input logic [NUM_REQ-1:0]    rel_req,
    input logic [NUM_REQ-1:0]    grant,
    input logic [NUM_REQ*TW-1:0] ticket,
    input logic                  rel_err
);

    // R3: mutual exclusion
    a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5: a holder that does not release keeps the lock, nobody else gains it
    a_r5_holder_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && (rel_req & grant) == '0) |=> grant == $past(grant));

    // R5: a valid release removes the releaser's grant
    a_r5_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((rel_req & grant) != '0) |=> ((grant & $past(rel_req & grant)) == '0));

    // R8: a release from a non-holder raises the error pulse
    a_r8_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
        ((rel_req & ~grant) != '0) |=> rel_err);

    // R8: the error pulse has no other cause
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> $past((rel_req & ~grant) != '0));

endmodule

bind abql_queue_lock abql_queue_lock_chk #(
    .NUM_REQ   (NUM_REQ),
    .NUM_SLOTS (NUM_SLOTS)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .acq_req (acq_req),
    .rel_req (rel_req),
    .grant   (grant),
    .ticket  (ticket),
    .rel_err (rel_err)
);

// File: tb/abql_queue_lock_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural model of next ticket and now-serving index predicts
// every cycle; a scoreboard queue holds the expected order of grants.
module abql_queue_lock_tb_top;

    localparam int N  = 4;
    localparam int S  = 4;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  acq_req = '0;
    logic [N-1:0]  rel_req = '0;
    logic [N-1:0]  grant;
    logic [N*TW-1:0] ticket;
    logic          rel_err;

    int checks = 0;
    int errors = 0;

    bit mq [N];
    int etk [N];
    int nt = 0;
    int serving = 0;
    int sb [$];
    logic [N-1:0] last_grant = '0;

    abql_queue_lock #(.NUM_REQ(N), .NUM_SLOTS(S)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .acq_req (acq_req),
        .rel_req (rel_req),
        .grant   (grant),
        .ticket  (ticket),
        .rel_err (rel_err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_grant();
        logic [N-1:0] g;
        g = '0;
        for (int i = 0; i < N; i++) begin
            g[i] = mq[i] && (etk[i] == serving);
        end
        return g;
    endfunction

    // Driver: one cycle of stimulus, model update, scoreboard push, checks.
    task automatic step(input logic [N-1:0] acq, input logic [N-1:0] rel, input string tag);
        logic [N-1:0] g0;
        logic [N-1:0] acc;
        bit pre [N];
        logic bad;
        g0  = model_grant();
        acc = '0;
        bad = |(rel & ~g0);
        for (int i = 0; i < N; i++) pre[i] = mq[i];
        acq_req = acq;
        rel_req = rel;
        for (int i = 0; i < N; i++) begin
            if (rel[i] && g0[i]) begin
                mq[i] = 0;
                serving = (serving + 1) % S;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (acq[i] && !pre[i]) begin
                mq[i]  = 1;
                etk[i] = nt;
                nt     = (nt + 1) % S;
                acc[i] = 1'b1;
                sb.push_back(i);
            end
        end
        @(posedge clk);
        @(negedge clk);
        acq_req = '0;
        rel_req = '0;
        chk({tag, " grant"}, 32'(grant), 32'(model_grant()));
        chk({tag, " rel_err"}, 32'(rel_err), 32'(bad));
        for (int i = 0; i < N; i++) begin
            if (acc[i]) chk({tag, " ticket"}, 32'(ticket[i*TW +: TW]), 32'(etk[i]));
        end
    endtask

    // Monitor: each new holder must be the oldest accepted acquire (R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (grant != last_grant && grant != '0) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R6 grant order: actual %0h expected none", grant);
                end else begin
                    int e;
                    e = sb.pop_front();
                    if (grant !== (N'(1) << e)) begin
                        errors++;
                        $display("FAIL R6 grant order: actual %0h expected %0h", grant, N'(1) << e);
                    end
                end
            end
            last_grant = grant;
        end
    end

    task automatic run_tests();
        logic [N-1:0] g;
        repeat (3) @(negedge clk);
        chk("R1 reset grant", 32'(grant), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant after reset", 32'(grant), 32'd0);
        chk("R1 rel_err after reset", 32'(rel_err), 32'd0);

        step(4'b0001, 4'b0000, "R1 R2 first acquire");
        step(4'b1110, 4'b0000, "R4 simultaneous acquires");
        step(4'b0010, 4'b0000, "R9 repeat acquire");
        chk("R9 ticket kept", 32'(ticket[1*TW +: TW]), 32'd1);
        step(4'b0000, 4'b0100, "R8 release by waiter");
        chk("R8 ticket kept", 32'(ticket[2*TW +: TW]), 32'd2);
        step(4'b0000, 4'b0000, "R8 pulse ends");
        step(4'b0000, 4'b0001, "R5 handoff to next");
        step(4'b0001, 4'b0010, "R11 R7 release with wrapped acquire");
        chk("R7 wrapped ticket", 32'(ticket[0 +: TW]), 32'd0);
        step(4'b0000, 4'b0100, "R5 handoff");
        step(4'b0000, 4'b1000, "R5 handoff across wrap");
        step(4'b0000, 4'b0001, "R10 release with no waiter");
        chk("R10 free", 32'(grant), 32'd0);
        step(4'b1000, 4'b0000, "R10 late arrival");
        step(4'b0000, 4'b1000, "R10 release again");

        for (int r = 0; r < 40; r++) begin
            logic [N-1:0] a;
            logic [N-1:0] rl;
            g  = model_grant();
            a  = N'((r * 5 + 3) % 16);
            if (r % 4 == 3) rl = 4'b0101 & ~g;
            else            rl = g;
            step(a, rl, "R6 R11 mixed traffic");
        end
        for (int r = 0; r < 8; r++) begin
            step(4'b0000, model_grant(), "R5 drain");
        end
        chk("R10 drained", 32'(grant), 32'd0);
        chk("R6 scoreboard empty", 32'(sb.size()), 32'd0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule